// File: doc/BRIEF.md
# Energy-to-Pulse Frequency Converter

The block turns a stream of signed real-power samples into metering pulses. Each valid sample adds its magnitude to two energy accumulators. One has a coarse threshold and drives a pair of low-rate counter outputs. The other has a fine threshold and drives a high-rate calibration output. Every threshold crossing subtracts the threshold from its accumulator, so energy is carried over between pulses rather than discarded.

A 3-bit rate select picks both thresholds. All pulse outputs are active low. Their low time is counted in clock cycles and shrinks to half the measured pulse period when pulses come too fast for the nominal width. The two counter outputs take turns, so a stepper or counter coil sees alternating phases.

A watchdog suppresses creep at no load. A startup hold blocks all pulses after reset. A sign flag, updated only when the calibration pulse ends, reports negative power. Each sample's magnitude must not exceed the calibration threshold in force.

Top module: `e2p_pulse_conv`

## Requirements
- R1: Under reset, `cnt_a_o`, `cnt_b_o` and `cal_o` are 1 and `neg_o` is 0. For `STARTUP_CYC` cycles after reset is released, the accumulators stay clear and no pulse is emitted.
- R2: On each cycle with `pwr_valid_i` high, |`pwr_i`| (two's complement) is added to both accumulators. On a crossing, the threshold is subtracted and one pulse is requested. A constant power P therefore gives one calibration pulse every thr_cal/|P| cycles.
- R3: With `rate_sel_i` = {s2,s1,s0}, the counter threshold is 2^(LO_EXP - {s1,s0}). The calibration threshold is the counter threshold divided by M, with M = 64, 32, 16, 2048, 128, 64, 32, 16 for `rate_sel_i` = 0 to 7.
- R4: A calibration pulse is low for `HI_WIDTH` cycles. If the period measured up to its request is below 2*`HI_WIDTH`, it is low for half that period instead, with a minimum of 2 cycles.
- R5: A counter pulse follows the same rule as R4, using `LO_WIDTH`.
- R6: Counter pulses alternate between `cnt_a_o` and `cnt_b_o`, and the first one after reset goes to `cnt_a_o`. The two outputs are never low together, and their falling edges are at least 4 cycles apart.
- R7: A request that arrives while a pulse, or the `GAP_CYC` recovery after it, is in progress is held in a one-deep pending slot. The pending pulse starts in the cycle after the timer goes idle. Further requests during that time are dropped.
- R8: If no calibration crossing happens within `NOLOAD_CYC` cycles, both accumulators are cleared and no pulses result.
- R9: With `rate_sel_i` = 3'b011, the no-load clear of R8 is disabled.
- R10: `neg_o` changes only on a rising edge of `cal_o`. It then takes the sign of the last valid sample: 1 if negative, 0 otherwise.
- R11: Samples with `pwr_valid_i` low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_i | input | PWR_W | Signed real-power sample |
| pwr_valid_i | input | 1 | Sample strobe |
| rate_sel_i | input | 3 | Threshold and constant select |
| cnt_a_o | output | 1 | Counter phase A pulse, active low |
| cnt_b_o | output | 1 | Counter phase B pulse, active low |
| cal_o | output | 1 | Calibration pulse, active low |
| neg_o | output | 1 | Negative power flag |

## Verification
The hardest state to reach is the rate select that exempts no-load clearing. That setting has the smallest calibration threshold, so the calibration accumulator crosses often and the watchdog would never expire anyway. The bench makes the exemption visible by strobing a tiny sample only once every 20 cycles. This stretches the calibration period past the watchdog window, so pulses appear only if the exemption works. Queued requests are reached by driving a power that crosses every other cycle, so the pulse timer is always busy when the next request arrives.

// File: rtl/e2p_pkg.sv
package e2p_pkg;
  typedef enum logic [1:0] {T_IDLE, T_LOW, T_GAP} tmr_state_e;

  // log2 of counter-to-calibration threshold ratio
  function automatic int unsigned mult_log(input logic [2:0] sel);
    case (sel)
      3'd0: return 6;
      3'd1: return 5;
      3'd2: return 4;
      3'd3: return 11;
      3'd4: return 7;
      3'd5: return 6;
      3'd6: return 5;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/e2p_accum.sv
module e2p_accum #(
  parameter int ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] mag_i,
  input  logic [ACC_W-1:0] thr_i,
  output logic             cross_o,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, mag_i};
  assign cross_o = en_i && !clr_i && (sum >= {1'b0, thr_i});
  assign acc_o   = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clr_i)   acc_q <= '0;
    else if (cross_o) acc_q <= ACC_W'(sum - {1'b0, thr_i});
    else if (en_i)    acc_q <= ACC_W'(sum);
  end
endmodule

// File: rtl/e2p_pulse_timer.sv
module e2p_pulse_timer
  import e2p_pkg::*;
#(
  parameter int WIDTH = 322160,
  parameter int GAP   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic low_o,
  output logic done_o
);
  localparam int SAT = 2 * WIDTH;
  localparam int PW  = $clog2(SAT + 1) + 1;
  localparam int GW  = $clog2(GAP + 1) + 1;

  tmr_state_e       st_q;
  logic [PW-1:0]    per_q, last_q, cnt_q, per_use, half, weff;
  logic [GW-1:0]    gap_q;
  logic             pend_q, start;

  assign start   = (st_q == T_IDLE) && (req_i || pend_q);
  assign per_use = req_i ? per_q : last_q;
  assign half    = per_use >> 1;
  assign low_o   = (st_q == T_LOW);
  assign done_o  = (st_q == T_LOW) && (cnt_q == PW'(1));

  always_comb begin
    if (half >= PW'(WIDTH)) weff = PW'(WIDTH);
    else if (half < PW'(2)) weff = PW'(2);
    else                    weff = half;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= PW'(SAT);
      last_q <= PW'(SAT);
    end else if (req_i) begin
      per_q  <= PW'(1);
      last_q <= per_q;
    end else if (per_q < PW'(SAT)) begin
      per_q  <= per_q + PW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= T_IDLE;
      cnt_q  <= '0;
      gap_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (start)                       pend_q <= pend_q && req_i;
      else if (req_i && st_q != T_IDLE) pend_q <= 1'b1;
      case (st_q)
        T_IDLE: if (start) begin
          st_q  <= T_LOW;
          cnt_q <= weff;
        end
        T_LOW: begin
          if (cnt_q == PW'(1)) begin
            if (GAP == 0) st_q <= T_IDLE;
            else begin
              st_q  <= T_GAP;
              gap_q <= GW'(GAP);
            end
          end else cnt_q <= cnt_q - PW'(1);
        end
        default: begin
          if (gap_q <= GW'(1)) st_q <= T_IDLE;
          else gap_q <= gap_q - GW'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/e2p_pulse_conv.sv
module e2p_pulse_conv
  import e2p_pkg::*;
#(
  parameter int PWR_W       = 16,
  parameter int LO_EXP      = 24,
  parameter int LO_WIDTH    = 984376,
  parameter int HI_WIDTH    = 322160,
  parameter int GAP_CYC     = 2,
  parameter int STARTUP_CYC = 3579545,
  parameter int NOLOAD_CYC  = 4194304
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PWR_W-1:0] pwr_i,
  input  logic             pwr_valid_i,
  input  logic [2:0]       rate_sel_i,
  output logic             cnt_a_o,
  output logic             cnt_b_o,
  output logic             cal_o,
  output logic             neg_o
);
  localparam int ACC_W = ((LO_EXP > PWR_W) ? LO_EXP : PWR_W) + 2;
  localparam int SU_W  = $clog2(STARTUP_CYC + 1) + 1;
  localparam int WD_W  = $clog2(NOLOAD_CYC + 1) + 1;

  logic [ACC_W-1:0]    mag, lo_thr, hi_thr, lo_acc, hi_acc;
  logic signed [PWR_W:0] pwx;
  logic [SU_W-1:0]     su_q;
  logic [WD_W-1:0]     wd_q;
  logic                run_q, creep_en, wd_exp, acc_clr, acc_en;
  logic                lo_cross, hi_cross, lo_low, lo_done, hi_low, hi_done;
  logic                phase_q, neg_now_q, neg_q;

  assign pwx    = {pwr_i[PWR_W-1], pwr_i};
  assign mag    = pwr_i[PWR_W-1] ? ACC_W'(-pwx) : ACC_W'(pwx);
  assign lo_thr = ACC_W'(1) << (LO_EXP - int'(rate_sel_i[1:0]));
  assign hi_thr = lo_thr >> mult_log(rate_sel_i);

  assign creep_en = (rate_sel_i != 3'b011);
  assign wd_exp   = run_q && creep_en && (wd_q == WD_W'(NOLOAD_CYC - 1));
  assign acc_clr  = !run_q || wd_exp;
  assign acc_en   = run_q && pwr_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      su_q  <= '0;
      run_q <= 1'b0;
    end else if (!run_q) begin
      if (su_q == SU_W'(STARTUP_CYC - 1)) run_q <= 1'b1;
      else su_q <= su_q + SU_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     wd_q <= '0;
    else if (!run_q || !creep_en || hi_cross || wd_exp) wd_q <= '0;
    else                                             wd_q <= wd_q + WD_W'(1);
  end

  e2p_accum #(.ACC_W(ACC_W)) u_lo_acc (
    .clk_i, .rst_ni, .clr_i(acc_clr), .en_i(acc_en), .mag_i(mag),
    .thr_i(lo_thr), .cross_o(lo_cross), .acc_o(lo_acc)
  );
  e2p_accum #(.ACC_W(ACC_W)) u_hi_acc (
    .clk_i, .rst_ni, .clr_i(acc_clr), .en_i(acc_en), .mag_i(mag),
    .thr_i(hi_thr), .cross_o(hi_cross), .acc_o(hi_acc)
  );

  e2p_pulse_timer #(.WIDTH(LO_WIDTH), .GAP(GAP_CYC)) u_lo_tmr (
    .clk_i, .rst_ni, .req_i(lo_cross), .low_o(lo_low), .done_o(lo_done)
  );
  e2p_pulse_timer #(.WIDTH(HI_WIDTH), .GAP(GAP_CYC)) u_hi_tmr (
    .clk_i, .rst_ni, .req_i(hi_cross), .low_o(hi_low), .done_o(hi_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= 1'b0;
      neg_now_q <= 1'b0;
      neg_q     <= 1'b0;
    end else begin
      if (lo_done) phase_q <= !phase_q;
      if (acc_en)  neg_now_q <= pwr_i[PWR_W-1];
      if (hi_done) neg_q <= neg_now_q;
    end
  end

  assign cnt_a_o = !(lo_low && !phase_q);
  assign cnt_b_o = !(lo_low && phase_q);
  assign cal_o   = !hi_low;
  assign neg_o   = neg_q;
endmodule

// File: rtl/e2p_pulse_conv_chk.sv
module e2p_pulse_conv_chk #(
  parameter int HI_WIDTH = 8,
  parameter int ACC_W    = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_a_o,
  input logic             cnt_b_o,
  input logic             cal_o,
  input logic             neg_o,
  input logic             run_q,
  input logic             wd_exp,
  input logic [ACC_W-1:0] lo_acc,
  input logic [ACC_W-1:0] hi_acc
);
  logic [31:0] cal_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cal_run <= '0;
    else if (!cal_o) cal_run <= cal_run + 32'd1;
    else             cal_run <= '0;
  end

  p_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (cnt_a_o && cnt_b_o && cal_o));

  p_cal_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_run <= 32'(HI_WIDTH));

  p_phase_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_a_o || cnt_b_o);

  p_creep_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_exp |=> (lo_acc == '0 && hi_acc == '0));

  p_neg_edge_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(cal_o) |-> $stable(neg_o));
endmodule

bind e2p_pulse_conv e2p_pulse_conv_chk #(.HI_WIDTH(HI_WIDTH), .ACC_W(ACC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_a_o(cnt_a_o), .cnt_b_o(cnt_b_o),
  .cal_o(cal_o), .neg_o(neg_o), .run_q(run_q), .wd_exp(wd_exp),
  .lo_acc(lo_acc), .hi_acc(hi_acc)
);

// File: tb/e2p_pulse_conv_bench.sv
module e2p_pulse_conv_bench;
  localparam int PWR_W = 16;
  localparam int STARTUP = 64;

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0;
  logic [PWR_W-1:0] pwr = '0;
  logic [2:0] sel = '0;
  logic a, b, c, n;
  int checks = 0, errors = 0;

  always #5 clk = !clk;

  e2p_pulse_conv #(
    .PWR_W(PWR_W), .LO_EXP(18), .LO_WIDTH(20), .HI_WIDTH(8), .GAP_CYC(2),
    .STARTUP_CYC(STARTUP), .NOLOAD_CYC(200)
  ) u_e2p_pulse_conv (
    .clk_i(clk), .rst_ni(rst_n), .pwr_i(pwr), .pwr_valid_i(valid),
    .rate_sel_i(sel), .cnt_a_o(a), .cnt_b_o(b), .cal_o(c), .neg_o(n)
  );

  // monitor
  int cyc = 0, a_falls = 0, b_falls = 0, c_falls = 0;
  int a_run = 0, b_run = 0, c_run = 0, a_w = 0, b_w = 0, c_w = 0;
  int last_lo = -1, last_lo_cyc = 0, alt_err = 0, sep_err = 0, neg_err = 0;
  logic a_p = 1'b1, b_p = 1'b1, c_p = 1'b1, n_p = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      last_lo = -1; a_run = 0; b_run = 0; c_run = 0;
    end else begin
      if (a_p && !a) begin
        a_falls++;
        if (last_lo == 0) alt_err++;
        if (last_lo >= 0 && cyc - last_lo_cyc < 4) sep_err++;
        last_lo = 0; last_lo_cyc = cyc;
      end
      if (b_p && !b) begin
        b_falls++;
        if (last_lo != 0) alt_err++;
        if (last_lo >= 0 && cyc - last_lo_cyc < 4) sep_err++;
        last_lo = 1; last_lo_cyc = cyc;
      end
      if (c_p && !c) c_falls++;
      if (!a) a_run++; else if (!a_p) begin a_w = a_run; a_run = 0; end
      if (!b) b_run++; else if (!b_p) begin b_w = b_run; b_run = 0; end
      if (!c) c_run++; else if (!c_p) begin c_w = c_run; c_run = 0; end
      if (n !== n_p && !(c && !c_p)) neg_err++;
    end
    a_p = a; b_p = b; c_p = c; n_p = n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic restart(input logic [2:0] s, input int p, input logic v);
    @(negedge clk);
    rst_n = 1'b0; sel = s; pwr = PWR_W'(p); valid = v;
    wait_cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_r1;
    int c0;
    @(negedge clk);
    rst_n = 1'b0; sel = 3'd0; pwr = PWR_W'(512); valid = 1'b1;
    wait_cyc(3);
    check(a && b && c && !n, "R1 reset outputs", {a, b, c, n}, 4'b1110);
    c0 = c_falls;
    rst_n = 1'b1;
    wait_cyc(STARTUP - 4);
    check(c_falls == c0 && a && b, "R1 startup hold", c_falls - c0, 0);
    wait_cyc(44);
    check(c_falls > c0, "R1 pulses after hold", c_falls - c0, 1);
  endtask

  task automatic t_cal_full_r4;
    int c0;
    restart(3'd0, 128, 1'b1);   // thr 4096, period 32
    wait_cyc(STARTUP + 100);
    c0 = c_falls;
    wait_cyc(1600);
    check(c_falls - c0 >= 49 && c_falls - c0 <= 51, "R2 cal rate", c_falls - c0, 50);
    check(c_w == 8, "R4 full width", c_w, 8);
  endtask

  task automatic t_cal_half_r4;
    int c0;
    restart(3'd0, 512, 1'b1);   // period 8 -> width 4
    wait_cyc(STARTUP + 100);
    c0 = c_falls;
    wait_cyc(800);
    check(c_falls - c0 >= 99 && c_falls - c0 <= 101, "R2 cal rate fast", c_falls - c0, 100);
    check(c_w == 4, "R4 half-period width", c_w, 4);
  endtask

  task automatic t_pend_r7;
    int c0;
    restart(3'd0, 2048, 1'b1);  // period 2 -> 2 low + 2 gap + 1 idle
    wait_cyc(STARTUP + 100);
    c0 = c_falls;
    wait_cyc(500);
    check(c_falls - c0 >= 99 && c_falls - c0 <= 101, "R7 queued rate", c_falls - c0, 100);
    check(c_w == 2, "R7 min width", c_w, 2);
  endtask

  task automatic t_lo_half_r6;
    int a0, b0, e0, s0;
    restart(3'd7, 1024, 1'b1);  // counter thr 32768, period 32
    wait_cyc(STARTUP + 300);
    a0 = a_falls; b0 = b_falls; e0 = alt_err; s0 = sep_err;
    wait_cyc(640);
    check(a_falls - a0 >= 9 && a_falls - a0 <= 11, "R6 phase A count", a_falls - a0, 10);
    check(b_falls - b0 >= 9 && b_falls - b0 <= 11, "R6 phase B count", b_falls - b0, 10);
    check(alt_err == e0, "R6 alternation", alt_err - e0, 0);
    check(sep_err == s0, "R6 edge spacing", sep_err - s0, 0);
    check(a_w == 16, "R5 half-period width", a_w, 16);
  endtask

  task automatic t_lo_full_r5;
    int a0;
    restart(3'd2, 1024, 1'b1);  // counter thr 65536, period 64
    wait_cyc(STARTUP + 300);
    a0 = a_falls;
    wait_cyc(1280);
    check(a_falls - a0 >= 9 && a_falls - a0 <= 11, "R3 counter thr sel 2", a_falls - a0, 10);
    check(a_w == 20 && b_w == 20, "R5 full width", a_w, 20);
  endtask

  task automatic t_ratio_r3;
    int c0;
    restart(3'd4, 128, 1'b1);   // cal thr 2048, period 16
    wait_cyc(STARTUP + 100);
    c0 = c_falls;
    wait_cyc(1600);
    check(c_falls - c0 >= 99 && c_falls - c0 <= 101, "R3 cal ratio sel 4", c_falls - c0, 100);
  endtask

  task automatic t_creep_r8;
    int a0, b0, c0;
    restart(3'd0, 16, 1'b1);    // cal period 256 > window 200
    wait_cyc(STARTUP);
    a0 = a_falls; b0 = b_falls; c0 = c_falls;
    wait_cyc(3000);
    check(c_falls == c0, "R8 no cal pulses at creep", c_falls - c0, 0);
    check(a_falls == a0 && b_falls == b0, "R8 no counter pulses at creep", a_falls - a0, 0);
    pwr = PWR_W'(32);           // period 128 < window
    c0 = c_falls;
    wait_cyc(1500);
    check(c_falls - c0 >= 8, "R8 pulses above creep", c_falls - c0, 11);
  endtask

  task automatic t_creep_off_r9;
    int c0;
    restart(3'd3, 1, 1'b0);     // cal thr 16
    wait_cyc(STARTUP + 10);
    c0 = c_falls;
    repeat (100) begin          // one sample per 20 cycles: period 320
      valid = 1'b1;
      @(negedge clk);
      valid = 1'b0;
      wait_cyc(19);
    end
    check(c_falls - c0 >= 5, "R9 creep exemption", c_falls - c0, 6);
  endtask

  task automatic t_valid_r11;
    int c0, a0;
    restart(3'd0, 2048, 1'b0);
    wait_cyc(STARTUP);
    c0 = c_falls; a0 = a_falls;
    wait_cyc(500);
    check(c_falls == c0 && a_falls == a0, "R11 invalid samples ignored", c_falls - c0, 0);
  endtask

  task automatic t_neg_r10;
    int e0;
    restart(3'd0, -128, 1'b1);
    e0 = neg_err;
    wait_cyc(STARTUP + 200);
    check(n == 1'b1, "R10 negative flag set", n, 1);
    pwr = PWR_W'(128);
    wait_cyc(1);
    check(n == 1'b1 || (c && !c_p), "R10 flag held until cal edge", n, 1);
    wait_cyc(100);
    check(n == 1'b0, "R10 flag cleared", n, 0);
    check(neg_err == e0, "R10 changes only at cal rise", neg_err - e0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_cal_full_r4();
    t_cal_half_r4();
    t_pend_r7();
    t_lo_half_r6();
    t_lo_full_r5();
    t_ratio_r3();
    t_creep_r8();
    t_creep_off_r9();
    t_valid_r11();
    t_neg_r10();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule